// File: doc/BRIEF.md
# DAC Power-Up Configuration Sequencer

This block is the serial-bus master that puts a sixteen-channel voltage-output DAC into a known state after power-up. A one-cycle start pulse launches the sequence. First the DAC is reset, in one of two ways chosen per run: either a dedicated reset pin is held active for a fixed time, or a keyed software-reset frame goes out on the serial bus. A guard interval follows. Then six dither-configuration frames go out, and the output-span frame comes last. When the span frame has left the bus, the block raises done.

Each frame is 24 bits long: an 8-bit command followed by a 16-bit data word. The frame is shifted out MSB first while chip select is held low. The serial clock idles low. The data line changes only on the falling edge, so the DAC can sample it on the rising edge. The span code and the 32-bit dither-source word are captured when start is accepted. Pulse widths and guard times are given in nanoseconds and converted to system-clock cycles, rounded up.

The sequencer state machine has eight states:
- IDLE: waits for start.
- PIN_RST: holds the reset pin active.
- SOFT_SEND and SOFT_WAIT: launch the reset frame and wait for it to finish.
- GUARD: waits out the guard interval.
- CFG_SEND and CFG_WAIT: launch one configuration frame and wait for it to finish.
- DONE: holds done high.

Transitions:
- IDLE or DONE goes to PIN_RST or to SOFT_SEND on start, according to the reset-mode input.
- PIN_RST goes to GUARD when the pulse count expires.
- SOFT_SEND goes to SOFT_WAIT after one cycle.
- SOFT_WAIT goes to GUARD when the frame finishes.
- GUARD goes to CFG_SEND when the guard count expires.
- CFG_SEND goes to CFG_WAIT after one cycle.
- CFG_WAIT goes back to CFG_SEND when a frame finishes and frames remain, or to DONE after the seventh frame.

The serializer has three states:
- SH_IDLE goes to SH_BITS on a launch.
- SH_BITS goes to SH_GAP after the 48th half-period of the serial clock.
- SH_GAP goes back to SH_IDLE once chip select has been high for one full serial-clock period.

Top module: `dac_boot_seq`

## Requirements
- R1: After reset the block is idle, with busy, done and the reset pin low, chip select high and the serial clock low. A start pulse seen in IDLE or DONE raises busy in the next cycle. A start pulse seen while busy has no effect: no extra frames are sent and no extra reset is issued.
- R2: In pin mode (reset-mode input = 1), the reset pin goes high for exactly ceil(RST_PULSE_NS / CLK_PERIOD_NS) cycles, no reset frame is sent, and chip select stays high while the pin is high.
- R3: In frame mode (reset-mode input = 0), the first frame sent is command 0x70 with data 0x1234, and the reset pin never goes high.
- R4: From the end of the reset (pin falling, or chip select rising after the reset frame) to the start of the first configuration frame, at least ceil(GUARD_NS / CLK_PERIOD_NS) cycles pass with chip select high and the reset pin low.
- R5: After the reset, exactly seven frames follow, in this order: {0x51, 0xFFFF}, {0x90, source[15:0]}, {0xA0, source[31:16]}, {0xC0, 0x0000}, {0xD0, 0x0000}, {0xB0, 0x0000}, {0x40, span}.
- R6: Each frame is 24 bits long, command byte in bits 23:16 and data word in bits 15:0. Bits go out MSB first, one per rising edge of the serial clock, with chip select low for the whole frame. Rising edges are 2*SCLK_HALF system cycles apart. Data changes only while the serial clock is low, and the serial clock is low whenever chip select is high.
- R7: Chip select stays high for at least 2*SCLK_HALF system cycles (one serial-clock period) between consecutive frames.
- R8: The span frame's data word is the 3-bit span code zero-extended to 16 bits. The span code and the 32-bit source word are taken as they stand in the cycle start is accepted; later changes have no effect on the run.
- R9: Done rises after the span frame's chip-select gap, stays high for as long as start is low, and a start in DONE begins a new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to run the sequence |
| pin_reset_i | input | 1 | Reset mode: 1 = pulse the reset pin, 0 = send the keyed reset frame |
| span_i | input | 3 | Output-range code sent in the last frame |
| dsrc_i | input | 32 | Dither-source word; low half sent first, then high half |
| dac_rst_o | output | 1 | Active-high reset pin to the DAC |
| sclk_o | output | 1 | Serial clock, idles low |
| cs_n_o | output | 1 | Active-low chip select |
| mosi_o | output | 1 | Serial data to the DAC |
| busy_o | output | 1 | High while a sequence is in progress |
| done_o | output | 1 | High after the sequence completes, until the next start |

## Verification
The bench builds the block with an 8 ns clock period, a 100 ns reset pulse, a 25 ns guard time and SCLK_HALF = 2. Neither time is a whole number of clock cycles, so the round-up path is exercised: a 13-cycle reset pulse and a guard of at least 4 cycles. SCLK_HALF = 2 makes the divider count through more than one cycle per serial-clock half-period, which exposes any miscounted edge spacing or gap. Runs alternate between pin mode and frame mode. They use span codes and source words whose halves differ, so a swapped order or a dropped bit shows up in the decoded frames.

// File: rtl/dac_boot_pkg.sv
package dac_boot_pkg;

    localparam int CMD_W   = 8;
    localparam int DATA_W  = 16;
    localparam int FRAME_W = CMD_W + DATA_W;
    localparam int SPAN_W  = 3;
    localparam int SRC_W   = 2 * DATA_W;
    localparam int N_CFG   = 7;
    localparam int SLOT_W  = 3;

    localparam logic [SLOT_W-1:0] RESET_SLOT = 3'd7;

    localparam logic [CMD_W-1:0]  CMD_SOFT_RESET = 8'h70;
    localparam logic [DATA_W-1:0] SOFT_RESET_KEY = 16'h1234;
    localparam logic [CMD_W-1:0]  CMD_DITH_PWR   = 8'h51;
    localparam logic [CMD_W-1:0]  CMD_SRC_LO     = 8'h90;
    localparam logic [CMD_W-1:0]  CMD_SRC_HI     = 8'hA0;
    localparam logic [CMD_W-1:0]  CMD_SCL_LO     = 8'hC0;
    localparam logic [CMD_W-1:0]  CMD_SCL_HI     = 8'hD0;
    localparam logic [CMD_W-1:0]  CMD_INVERT     = 8'hB0;
    localparam logic [CMD_W-1:0]  CMD_SPAN       = 8'h40;

    typedef logic [FRAME_W-1:0] frame_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PIN_RST,
        ST_SOFT_SEND,
        ST_SOFT_WAIT,
        ST_GUARD,
        ST_CFG_SEND,
        ST_CFG_WAIT,
        ST_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_BITS,
        SH_GAP
    } ser_state_t;

endpackage

// File: rtl/dac_boot_frames.sv
module dac_boot_frames
    import dac_boot_pkg::*;
(
    input  logic [SLOT_W-1:0] slot_i,
    input  logic [SRC_W-1:0]  dsrc_i,
    input  logic [SPAN_W-1:0] span_i,
    output frame_t            frame_o
);

    always_comb begin
        unique case (slot_i)
            3'd0: frame_o = {CMD_DITH_PWR, {DATA_W{1'b1}}};
            3'd1: frame_o = {CMD_SRC_LO, dsrc_i[DATA_W-1:0]};
            3'd2: frame_o = {CMD_SRC_HI, dsrc_i[SRC_W-1:DATA_W]};
            3'd3: frame_o = {CMD_SCL_LO, {DATA_W{1'b0}}};
            3'd4: frame_o = {CMD_SCL_HI, {DATA_W{1'b0}}};
            3'd5: frame_o = {CMD_INVERT, {DATA_W{1'b0}}};
            3'd6: frame_o = {CMD_SPAN, {(DATA_W-SPAN_W){1'b0}}, span_i};
            default: frame_o = {CMD_SOFT_RESET, SOFT_RESET_KEY};
        endcase
    end

endmodule

// File: rtl/dac_boot_ser.sv
module dac_boot_ser
    import dac_boot_pkg::*;
#(
    parameter int SCLK_HALF = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   go_i,
    input  frame_t frame_i,
    output logic   fin_o,
    output logic   sclk_o,
    output logic   cs_n_o,
    output logic   mosi_o
);

    localparam int PH_N  = 2 * FRAME_W;
    localparam int PH_W  = $clog2(PH_N);
    localparam int DIV_W = (2 * SCLK_HALF > 1) ? $clog2(2 * SCLK_HALF) : 1;

    ser_state_t       st, st_nx;
    logic [DIV_W-1:0] div;
    logic [PH_W-1:0]  ph;
    frame_t           sh;

    logic div_last, gap_last, ph_last;

    assign div_last = (div == DIV_W'(SCLK_HALF - 1));
    assign gap_last = (div == DIV_W'(2 * SCLK_HALF - 1));
    assign ph_last  = (ph == PH_W'(PH_N - 1));

    always_comb begin
        st_nx = st;
        unique case (st)
            SH_IDLE: if (go_i) st_nx = SH_BITS;
            SH_BITS: if (div_last && ph_last) st_nx = SH_GAP;
            SH_GAP:  if (gap_last) st_nx = SH_IDLE;
            default: st_nx = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= SH_IDLE;
            div <= '0;
            ph  <= '0;
            sh  <= '0;
        end else begin
            st <= st_nx;
            unique case (st)
                SH_IDLE: begin
                    div <= '0;
                    ph  <= '0;
                    if (go_i) sh <= frame_i;
                end
                SH_BITS: begin
                    if (div_last) begin
                        div <= '0;
                        if (!ph_last) ph <= ph + 1'b1;
                        if (ph[0]) sh <= {sh[FRAME_W-2:0], 1'b0};
                    end else begin
                        div <= div + 1'b1;
                    end
                end
                SH_GAP: div <= gap_last ? '0 : div + 1'b1;
                default: div <= '0;
            endcase
        end
    end

    always_comb begin
        cs_n_o = (st != SH_BITS);
        sclk_o = (st == SH_BITS) && ph[0];
        mosi_o = (st == SH_BITS) ? sh[FRAME_W-1] : 1'b0;
        fin_o  = (st == SH_GAP) && gap_last;
    end

    // R6
    idle_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o);

    // R6
    data_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

endmodule

// File: rtl/dac_boot_seq.sv
module dac_boot_seq
    import dac_boot_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 8,
    parameter int RST_PULSE_NS  = 100,
    parameter int GUARD_NS      = 25,
    parameter int SCLK_HALF     = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        pin_reset_i,
    input  logic [2:0]  span_i,
    input  logic [31:0] dsrc_i,
    output logic        dac_rst_o,
    output logic        sclk_o,
    output logic        cs_n_o,
    output logic        mosi_o,
    output logic        busy_o,
    output logic        done_o
);

    localparam int RST_CYC   = (RST_PULSE_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    localparam int GUARD_CYC = (GUARD_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    localparam int CNT_MAX   = (RST_CYC > GUARD_CYC) ? RST_CYC : GUARD_CYC;
    localparam int CNT_W     = $clog2(CNT_MAX + 1);
    localparam int GAP_CYC   = 2 * SCLK_HALF;
    localparam int CSH_W     = $clog2(GAP_CYC + 1);

    seq_state_t        st, st_nx;
    logic [CNT_W-1:0]  cnt;
    logic [SLOT_W-1:0] idx;
    logic [SPAN_W-1:0] span_q;
    logic [SRC_W-1:0]  dsrc_q;
    logic              accept;
    logic              go, fin;
    logic [SLOT_W-1:0] slot;
    frame_t            frame;

    assign accept = start_i && ((st == ST_IDLE) || (st == ST_DONE));

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE, ST_DONE:
                if (start_i) st_nx = pin_reset_i ? ST_PIN_RST : ST_SOFT_SEND;
            ST_PIN_RST:
                if (cnt == CNT_W'(RST_CYC - 1)) st_nx = ST_GUARD;
            ST_SOFT_SEND:
                st_nx = ST_SOFT_WAIT;
            ST_SOFT_WAIT:
                if (fin) st_nx = ST_GUARD;
            ST_GUARD:
                if (cnt == CNT_W'(GUARD_CYC - 1)) st_nx = ST_CFG_SEND;
            ST_CFG_SEND:
                st_nx = ST_CFG_WAIT;
            ST_CFG_WAIT:
                if (fin) st_nx = (idx == SLOT_W'(N_CFG - 1)) ? ST_DONE : ST_CFG_SEND;
            default:
                st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            idx    <= '0;
            span_q <= '0;
            dsrc_q <= '0;
        end else begin
            st <= st_nx;
            if (st_nx != st)
                cnt <= '0;
            else if ((st == ST_PIN_RST) || (st == ST_GUARD))
                cnt <= cnt + 1'b1;
            if (accept) begin
                idx    <= '0;
                span_q <= span_i;
                dsrc_q <= dsrc_i;
            end else if ((st == ST_CFG_WAIT) && fin && (idx != SLOT_W'(N_CFG - 1))) begin
                idx <= idx + 1'b1;
            end
        end
    end

    always_comb begin
        dac_rst_o = (st == ST_PIN_RST);
        busy_o    = (st != ST_IDLE) && (st != ST_DONE);
        done_o    = (st == ST_DONE);
        go        = (st == ST_SOFT_SEND) || (st == ST_CFG_SEND);
        slot      = (st == ST_SOFT_SEND) ? RESET_SLOT : idx;
    end

    dac_boot_frames u_frames (
        .slot_i  (slot),
        .dsrc_i  (dsrc_q),
        .span_i  (span_q),
        .frame_o (frame)
    );

    dac_boot_ser #(.SCLK_HALF(SCLK_HALF)) u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_i    (go),
        .frame_i (frame),
        .fin_o   (fin),
        .sclk_o  (sclk_o),
        .cs_n_o  (cs_n_o),
        .mosi_o  (mosi_o)
    );

    // Checker counters for the timing windows below.
    logic [CNT_W-1:0] pin_run;
    logic [CNT_W-1:0] quiet;
    logic [CSH_W-1:0] csh;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_run <= '0;
            quiet   <= '0;
            csh     <= CSH_W'(GAP_CYC);
        end else begin
            pin_run <= dac_rst_o ? pin_run + 1'b1 : '0;
            if (dac_rst_o || !cs_n_o)
                quiet <= '0;
            else if (quiet < CNT_W'(GUARD_CYC))
                quiet <= quiet + 1'b1;
            if (!cs_n_o)
                csh <= '0;
            else if (csh < CSH_W'(GAP_CYC))
                csh <= csh + 1'b1;
        end
    end

    // R2
    rst_pulse_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dac_rst_o |-> (pin_run < CNT_W'(RST_CYC)));

    // R2
    rst_pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_rst_o) |-> (pin_run == CNT_W'(RST_CYC)));

    // R2
    no_frame_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dac_rst_o |-> cs_n_o);

    // R4
    guard_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cs_n_o) && (st == ST_CFG_WAIT) && (idx == '0)) |-> (quiet >= CNT_W'(GUARD_CYC)));

    // R7
    frame_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> (csh >= CSH_W'(GAP_CYC)));

    // R9
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    // R1
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !dac_rst_o) |=> !dac_rst_o);

endmodule

// File: tb/dac_boot_seq_tb.sv
`timescale 1ns/1ps
module dac_boot_seq_tb;

    localparam int CLK_NS  = 8;
    localparam int RST_NS  = 100;
    localparam int GRD_NS  = 25;
    localparam int HALF    = 2;
    localparam int EXP_RST = (RST_NS + CLK_NS - 1) / CLK_NS;
    localparam int EXP_GRD = (GRD_NS + CLK_NS - 1) / CLK_NS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        pin_mode = 1'b0;
    logic [2:0]  span = '0;
    logic [31:0] dsrc = '0;
    logic        dac_rst, sclk, cs_n, mosi, busy, done;

    dac_boot_seq #(
        .CLK_PERIOD_NS (CLK_NS),
        .RST_PULSE_NS  (RST_NS),
        .GUARD_NS      (GRD_NS),
        .SCLK_HALF     (HALF)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .pin_reset_i (pin_mode),
        .span_i      (span),
        .dsrc_i      (dsrc),
        .dac_rst_o   (dac_rst),
        .sclk_o      (sclk),
        .cs_n_o      (cs_n),
        .mosi_o      (mosi),
        .busy_o      (busy),
        .done_o      (done)
    );

    always #(CLK_NS / 2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=0x%0h exp=0x%0h", req, what, act, exp);
        end
    endtask

    // Behavioural bus model: expected frames, decoded frames, timing counters.
    logic [23:0] exp_q[$];
    int          gaps[$];
    int          rst_hi, nbits, last_rise, frames, cs_gap;
    logic [23:0] shreg;
    logic        p_sclk = 1'b0, p_cs = 1'b1, p_mosi = 1'b0;

    always @(posedge clk) cyc++;

    always @(negedge clk) begin
        if (rst_n) begin
            if (cs_n && sclk) chk(0, "R6", "sclk high with cs high", 1, 0);
            if (sclk && p_sclk && (mosi != p_mosi)) chk(0, "R6", "data moved while sclk high", mosi, p_mosi);
            if (dac_rst && !cs_n) chk(0, "R2", "frame during reset pulse", 0, 1);
            if (dac_rst) rst_hi++;
            if (!cs_n && p_cs) begin
                gaps.push_back(cs_gap);
                nbits = 0;
            end
            if (!cs_n && sclk && !p_sclk) begin
                if (nbits > 0) chk((cyc - last_rise) == 2 * HALF, "R6", "sclk period", cyc - last_rise, 2 * HALF);
                last_rise = cyc;
                shreg = {shreg[22:0], mosi};
                nbits++;
            end
            if (cs_n && !p_cs) begin
                frames++;
                chk(nbits == 24, "R6", "bits per frame", nbits, 24);
                if (exp_q.size() == 0) chk(0, "R5", "unexpected frame", shreg, 0);
                else begin
                    logic [23:0] e;
                    e = exp_q.pop_front();
                    chk(shreg == e, "R5", "frame content", shreg, e);
                end
            end
            if (!cs_n || dac_rst) cs_gap = 0;
            else cs_gap++;
            p_sclk = sclk;
            p_cs   = cs_n;
            p_mosi = mosi;
        end
    end

    task automatic run(input bit pm, input logic [2:0] sp, input logic [31:0] ds, input bit poke);
        int n;
        int first_cfg;
        int nexp;
        exp_q.delete();
        gaps.delete();
        rst_hi = 0;
        frames = 0;
        if (!pm) exp_q.push_back({8'h70, 16'h1234});
        exp_q.push_back({8'h51, 16'hFFFF});
        exp_q.push_back({8'h90, ds[15:0]});
        exp_q.push_back({8'hA0, ds[31:16]});
        exp_q.push_back({8'hC0, 16'h0000});
        exp_q.push_back({8'hD0, 16'h0000});
        exp_q.push_back({8'hB0, 16'h0000});
        exp_q.push_back({8'h40, 13'b0, sp});
        nexp = exp_q.size();

        @(negedge clk);
        pin_mode = pm;
        span     = sp;
        dsrc     = ds;
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
        chk(busy == 1'b1, "R1", "busy after start", busy, 1);
        chk(done == 1'b0, "R9", "done cleared by start", done, 0);
        // R8: inputs changed after acceptance must not leak into the run
        span     = ~sp;
        dsrc     = ~ds;
        pin_mode = ~pm;
        if (poke) begin
            repeat (6) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (300) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk(done == 1'b1, "R9", "done after sequence", done, 1);
        chk(busy == 1'b0, "R1", "busy low when done", busy, 0);
        chk(frames == nexp, "R1", "frame count (start while busy ignored)", frames, nexp);
        chk(exp_q.size() == 0, "R5", "frames left unsent", exp_q.size(), 0);
        if (pm) chk(rst_hi == EXP_RST, "R2", "reset pin high cycles", rst_hi, EXP_RST);
        else    chk(rst_hi == 0, "R3", "reset pin idle in frame mode", rst_hi, 0);
        first_cfg = pm ? 0 : 1;
        if (gaps.size() > first_cfg)
            chk(gaps[first_cfg] >= EXP_GRD, "R4", "guard before first config frame", gaps[first_cfg], EXP_GRD);
        else
            chk(0, "R4", "first config frame missing", gaps.size(), first_cfg + 1);
        for (int i = 1; i < gaps.size(); i++)
            chk(gaps[i] >= 2 * HALF, "R7", "chip select gap", gaps[i], 2 * HALF);
        n = 0;
        repeat (25) begin
            @(negedge clk);
            if (!done) n++;
        end
        chk(n == 0, "R9", "done held without start", n, 0);
        chk(cs_n == 1'b1, "R9", "bus quiet in DONE", cs_n, 1);
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R1", "reset busy", busy, 0);
        chk(done == 1'b0, "R1", "reset done", done, 0);
        chk(dac_rst == 1'b0, "R1", "reset pin", dac_rst, 0);
        chk(cs_n == 1'b1, "R1", "reset cs_n", cs_n, 1);
        chk(sclk == 1'b0, "R1", "reset sclk", sclk, 0);
        repeat (5) @(negedge clk);

        run(1'b1, 3'd3, 32'hA5A5_3C3C, 1'b1);   // pin mode, start poked while busy
        run(1'b0, 3'd7, 32'hFFFF_0001, 1'b0);   // frame mode, restart from DONE
        run(1'b0, 3'd0, 32'h0000_8000, 1'b1);   // frame mode, poke while busy
        run(1'b1, 3'd5, 32'h1357_9BDF, 1'b0);   // pin mode, R8 span code 5

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_NS * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog act=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule